// File: doc/BRIEF.md
# Copyback Miss Controller with Victim Push Buffer

This block sits on the miss path of a copyback data cache. The cache presents one miss request at a time. The request carries the address of the line to fetch, the address of the line being evicted, that line's contents, and a flag that says whether the evicted line was modified. When the evicted line is modified, the controller copies it into a one-line push buffer and starts the burst read for the new line straight away. The write-back is deferred until the read has returned. A clean victim needs no push buffer and no write. The cache only sees the fill.

Only after the last read beat has arrived does the controller burst the saved victim out to memory. It then marks the push buffer empty. The bus port has a single master, so at most one burst is in flight at any time. The controller also watches the empty flag of a neighbouring store buffer, and it will not start a new fill while queued stores are still waiting. The `busy` output tells the requester to hold its miss until the controller can accept it.

Top module: `push_ctrl`

## Requirements
- R1: During reset and after its release, with no miss pending, `bus_req`, `bus_we`, `fill_done` and `push_pending` are 0 and `bus_addr` and `bus_wdata` are 0.
- R2: `busy` is 1 whenever the controller is not idle or `sb_empty` is 0. A miss is accepted at a rising edge where `miss_valid` is 1 and `busy` is 0, and nowhere else.
- R3: In the cycle after a miss is accepted, `bus_req` is 1 with `bus_we` 0. This read burst for the new line always starts before any write-back of the victim.
- R4: A burst has 4 beats of 32 bits. `bus_addr` is the line base (the request address with its low 4 bits forced to 0) plus 4 times the beat index, with beats in ascending order. The beat index advances only on a cycle with `bus_ack` 1, and otherwise `bus_addr` holds.
- R5: `fill_done` pulses for one cycle, in the cycle after the fourth read beat is acknowledged. At that time `fill_data` holds read beat k in bits [32k+31:32k].
- R6: A miss accepted with `miss_victim_dirty` 1 copies the victim line and its base address into the push buffer. `push_pending` is 1 from the cycle after acceptance until the write-back ends, and the stored data does not change in that time.
- R7: After a dirty-victim miss, the write burst starts in the same cycle as `fill_done`, with `bus_we` 1 and `bus_addr` at the victim base. The write data for beat k is bits [32k+31:32k] of the victim line.
- R8: `push_pending` falls and the controller returns to idle in the cycle after the fourth write beat is acknowledged.
- R9: A miss accepted with `miss_victim_dirty` 0 performs only the read burst. No write cycle follows, and the controller returns to idle after `fill_done`.
- R10: No new miss is accepted while a write-back is pending: `busy` stays 1 while `push_pending` is 1.
- R11: Reads and writes never overlap. `bus_we` stays constant from the first beat of a burst to its last acknowledged beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_fill_addr | input | 32 | Address of the line to fetch |
| miss_victim_dirty | input | 1 | Evicted line is modified |
| miss_victim_addr | input | 32 | Address of the evicted line |
| miss_victim_data | input | 128 | Contents of the evicted line |
| sb_empty | input | 1 | Store buffer has no pending writes |
| busy | output | 1 | Requester must hold its miss |
| fill_done | output | 1 | One-cycle pulse: the fill line is complete |
| fill_data | output | 128 | Assembled fill line |
| push_pending | output | 1 | Push buffer holds a victim not yet written |
| bus_req | output | 1 | Burst in progress |
| bus_we | output | 1 | 1 for a write burst, 0 for a read burst |
| bus_addr | output | 32 | Address of the current beat |
| bus_wdata | output | 32 | Write data of the current beat |
| bus_rdata | input | 32 | Read data of the current beat |
| bus_ack | input | 1 | Current beat completes at this edge |

## Verification
The bench goes after the ordering corner: a dirty miss whose write-back goes out before the fill, or overlaps it. A design with that fault would show `bus_we` rising before `fill_done`. It also covers acks with wait states between them. A counter that advances without an ack would skip beats or produce addresses that are not in ascending order.

A miss is held while the store buffer is not empty, and another miss is held during a write-back. A design with a missing interlock would accept such a miss early and start a read while stores or the victim are still pending. A clean victim must produce no write cycle at all. Unaligned request addresses must still give bursts that start at the line base.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_FILL = 2'd1,
    PB_PUSH = 2'd2
  } pb_state_e;
endpackage

// File: rtl/pbc_seq.sv
module pbc_seq
  import pbc_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  input  logic                       sb_empty,
  input  logic                       push_valid,
  input  logic                       bus_ack,
  output pb_state_e                  state,
  output logic [$clog2(BEATS)-1:0]   beat,
  output logic                       accept,
  output logic                       burst_last
);
  localparam int BSEL_W = $clog2(BEATS);

  pb_state_e          state_d;
  logic [BSEL_W-1:0]  beat_d;
  logic               beat_en;

  assign accept     = (state == PB_IDLE) && miss_valid && sb_empty;
  assign burst_last = (state != PB_IDLE) && bus_ack && (beat == BSEL_W'(BEATS - 1));

  always_comb begin
    state_d = state;
    case (state)
      PB_IDLE: if (accept) state_d = PB_FILL;
      PB_FILL: if (burst_last) state_d = push_valid ? PB_PUSH : PB_IDLE;
      PB_PUSH: if (burst_last) state_d = PB_IDLE;
      default: state_d = PB_IDLE;
    endcase
  end

  always_comb begin
    beat_en = accept || ((state != PB_IDLE) && bus_ack);
    if (accept || burst_last) beat_d = '0;
    else                      beat_d = beat + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PB_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (beat_en) beat <= beat_d;
  end

  AST_FILL_NEEDS_SB_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PB_FILL && $past(state) == PB_IDLE) |-> $past(sb_empty)); // R2
endmodule

// File: rtl/pbc_victim_buf.sv
module pbc_victim_buf #(
  parameter int AW     = 32,
  parameter int BEAT_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture_en,
  input  logic                      release_en,
  input  logic [AW-1:0]             cap_addr,
  input  logic [BEAT_W*BEATS-1:0]   cap_line,
  input  logic [$clog2(BEATS)-1:0]  beat_sel,
  output logic                      valid,
  output logic [AW-1:0]             addr,
  output logic [BEAT_W-1:0]         beat_data
);
  localparam int LINE_W = BEAT_W * BEATS;

  logic [LINE_W-1:0] line_q;
  logic              valid_d;

  always_comb begin
    valid_d = valid;
    if (capture_en)      valid_d = 1'b1;
    else if (release_en) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      addr   <= '0;
    end else if (capture_en) begin
      line_q <= cap_line;
      addr   <= cap_addr;
    end
  end

  assign beat_data = line_q[beat_sel*BEAT_W +: BEAT_W];

  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !release_en) |=> (valid && $stable(line_q) && $stable(addr))); // R6
endmodule

// File: rtl/pbc_fill_asm.sv
module pbc_fill_asm #(
  parameter int BEAT_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat_en,
  input  logic [$clog2(BEATS)-1:0]  beat_idx,
  input  logic [BEAT_W-1:0]         rdata,
  input  logic                      last_en,
  output logic [BEAT_W*BEATS-1:0]   line,
  output logic                      done
);
  for (genvar k = 0; k < BEATS; k++) begin : g_beat
    logic hit;
    assign hit = beat_en && (beat_idx == k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   line[k*BEAT_W +: BEAT_W] <= '0;
      else if (hit) line[k*BEAT_W +: BEAT_W] <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= last_en;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
endmodule

// File: rtl/push_ctrl.sv
module push_ctrl
  import pbc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int BEAT_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  input  logic [AW-1:0]            miss_fill_addr,
  input  logic                     miss_victim_dirty,
  input  logic [AW-1:0]            miss_victim_addr,
  input  logic [BEAT_W*BEATS-1:0]  miss_victim_data,
  input  logic                     sb_empty,
  output logic                     busy,
  output logic                     fill_done,
  output logic [BEAT_W*BEATS-1:0]  fill_data,
  output logic                     push_pending,
  output logic                     bus_req,
  output logic                     bus_we,
  output logic [AW-1:0]            bus_addr,
  output logic [BEAT_W-1:0]        bus_wdata,
  input  logic [BEAT_W-1:0]        bus_rdata,
  input  logic                     bus_ack
);
  localparam int BSEL_W    = $clog2(BEATS);
  localparam int BYTE_OFF  = $clog2(BEAT_W / 8);
  localparam int LINE_OFF  = BSEL_W + BYTE_OFF;
  localparam int BEAT_BYTES = BEAT_W / 8;

  pb_state_e         state;
  logic [BSEL_W-1:0] beat;
  logic              accept;
  logic              burst_last;
  logic [AW-1:0]     fill_base;
  logic [AW-1:0]     push_addr;
  logic [BEAT_W-1:0] push_beat;
  logic [AW-1:0]     cur_base;
  logic              push_capture;
  logic              push_release;

  pbc_seq #(.BEATS(BEATS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .sb_empty   (sb_empty),
    .push_valid (push_pending),
    .bus_ack    (bus_ack),
    .state      (state),
    .beat       (beat),
    .accept     (accept),
    .burst_last (burst_last)
  );

  assign push_capture = accept && miss_victim_dirty;
  assign push_release = (state == PB_PUSH) && burst_last;

  pbc_victim_buf #(.AW(AW), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_vbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (push_capture),
    .release_en (push_release),
    .cap_addr   ({miss_victim_addr[AW-1:LINE_OFF], {LINE_OFF{1'b0}}}),
    .cap_line   (miss_victim_data),
    .beat_sel   (beat),
    .valid      (push_pending),
    .addr       (push_addr),
    .beat_data  (push_beat)
  );

  pbc_fill_asm #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_en  ((state == PB_FILL) && bus_ack),
    .beat_idx (beat),
    .rdata    (bus_rdata),
    .last_en  ((state == PB_FILL) && burst_last),
    .line     (fill_data),
    .done     (fill_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill_base <= '0;
    else if (accept) fill_base <= {miss_fill_addr[AW-1:LINE_OFF], {LINE_OFF{1'b0}}};
  end

  always_comb begin
    cur_base  = (state == PB_PUSH) ? push_addr : fill_base;
    bus_req   = (state != PB_IDLE);
    bus_we    = (state == PB_PUSH);
    bus_addr  = bus_req ? {cur_base[AW-1:LINE_OFF], beat, {BYTE_OFF{1'b0}}} : '0;
    bus_wdata = bus_we ? push_beat : '0;
    busy      = (state != PB_IDLE) || !sb_empty;
  end

  AST_WB_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> fill_done); // R7
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr))); // R4
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !burst_last) |=> (bus_addr == $past(bus_addr) + AW'(BEAT_BYTES))); // R4
  AST_INVAL_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(push_pending) |-> $past(bus_we && bus_ack)); // R8
  AST_BUSY_WHILE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_pending |-> busy); // R10
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !burst_last) |=> (bus_req && bus_we == $past(bus_we))); // R11
endmodule

// File: tb/sim_push_ctrl.sv
`timescale 1ns/1ps
module sim_push_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_fill_addr = '0;
  logic         miss_victim_dirty = 1'b0;
  logic [31:0]  miss_victim_addr = '0;
  logic [127:0] miss_victim_data = '0;
  logic         sb_empty = 1'b1;
  logic         busy, fill_done, push_pending, bus_req, bus_we;
  logic [127:0] fill_data;
  logic [31:0]  bus_addr, bus_wdata;
  logic [31:0]  bus_rdata = '0;
  logic         bus_ack = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int ack_mode = 0;
  int cyc = 0;
  int write_beats = 0;
  int busy_in_push_bad = 0;

  always #4 clk = ~clk;

  push_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_fill_addr(miss_fill_addr),
    .miss_victim_dirty(miss_victim_dirty), .miss_victim_addr(miss_victim_addr),
    .miss_victim_data(miss_victim_data), .sb_empty(sb_empty), .busy(busy),
    .fill_done(fill_done), .fill_data(fill_data), .push_pending(push_pending),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // behavioural reference model
  int           m_st = 0;
  int           m_beat = 0;
  bit           m_pv = 0;
  bit           m_done = 0;
  logic [31:0]  m_fill_base = '0;
  logic [31:0]  m_push_base = '0;
  logic [31:0]  m_push [4];
  logic [31:0]  m_line [4];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_pv = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (miss_valid && sb_empty) begin
          m_fill_base = miss_fill_addr & ~32'hF;
          if (miss_victim_dirty) begin
            m_pv = 1;
            m_push_base = miss_victim_addr & ~32'hF;
            for (int k = 0; k < 4; k++) m_push[k] = miss_victim_data[k*32 +: 32];
          end
          m_st = 1; m_beat = 0;
        end
      end else if (bus_ack) begin
        if (m_st == 1) m_line[m_beat] = bus_rdata;
        if (m_beat == 3) begin
          m_beat = 0;
          if (m_st == 1) begin
            m_done = 1;
            m_st = m_pv ? 2 : 0;
          end else begin
            m_pv = 0;
            m_st = 0;
          end
        end else begin
          m_beat = m_beat + 1;
        end
      end
    end
  end

  // bus slave: ack pattern and read data, driven after the edge
  always @(posedge clk) begin
    #1;
    case (ack_mode)
      0: bus_ack = bus_req;
      1: bus_ack = bus_req && (cyc % 3 == 0);
      default: bus_ack = bus_req && (cyc % 2 == 1);
    endcase
    bus_rdata = {bus_addr[15:0], 16'h5A00 ^ bus_addr[31:16]} ^ 32'h0F0F_3C3C;
    if (bus_req && bus_we && bus_ack) write_beats = write_beats + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    logic [31:0] e_addr, e_wdata;
    logic [127:0] e_line;
    e_addr  = (m_st == 1) ? m_fill_base + 32'(4 * m_beat) :
              (m_st == 2) ? m_push_base + 32'(4 * m_beat) : 32'h0;
    e_wdata = (m_st == 2) ? m_push[m_beat] : 32'h0;
    e_line  = {m_line[3], m_line[2], m_line[1], m_line[0]};
    chk(busy == ((m_st != 0) || !sb_empty), "R2 busy", 128'(busy), 128'((m_st != 0) || !sb_empty));
    chk(bus_req == (m_st != 0), "R3 bus_req", 128'(bus_req), 128'(m_st != 0));
    chk(bus_we == (m_st == 2), "R7 bus_we", 128'(bus_we), 128'(m_st == 2));
    chk(bus_addr == e_addr, "R4 bus_addr", 128'(bus_addr), 128'(e_addr));
    chk(bus_wdata == e_wdata, "R7 bus_wdata", 128'(bus_wdata), 128'(e_wdata));
    chk(fill_done == m_done, "R5 fill_done", 128'(fill_done), 128'(m_done));
    if (m_done) chk(fill_data == e_line, "R5 fill_data", fill_data, e_line);
    chk(push_pending == m_pv, "R6 push_pending", 128'(push_pending), 128'(m_pv));
    if (push_pending && !busy) busy_in_push_bad = busy_in_push_bad + 1;
  end

  task automatic do_miss(input logic [31:0] fa, input bit dirty, input logic [31:0] va,
                         input logic [127:0] vd);
    @(posedge clk); #1;
    miss_valid = 1'b1; miss_fill_addr = fa; miss_victim_dirty = dirty;
    miss_victim_addr = va; miss_victim_data = vd;
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!bus_req && !push_pending) break;
    end
  endtask

  initial begin
    #200_000_000;
    mismatched = mismatched + 1;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int wb0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_req && !bus_we && !fill_done && !push_pending && bus_addr == 0 && bus_wdata == 0,
        "R1 reset outputs", {bus_req, bus_we, fill_done, push_pending}, 128'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_req && !push_pending, "R1 after release", {bus_req, push_pending}, 128'h0);

    // R9: clean victim, no write cycle
    wb0 = write_beats;
    do_miss(32'h0000_1234, 1'b0, 32'h0000_8800, {4{32'hDEAD_BEEF}});
    wait_idle();
    chk(write_beats == wb0, "R9 no write for clean victim", 128'(write_beats - wb0), 128'h0);

    // R3 R7 R8: dirty victim, fast acks, unaligned addresses
    wb0 = write_beats;
    do_miss(32'h0001_004B, 1'b1, 32'h0002_0077,
            128'h1111_2222_3333_4444_5555_6666_7777_8888);
    wait_idle();
    chk(write_beats - wb0 == 4, "R7 four write beats", 128'(write_beats - wb0), 128'd4);
    chk(!push_pending, "R8 push buffer invalid after write-back", 128'(push_pending), 128'h0);

    // R4 wait states, R2 store buffer not empty
    ack_mode = 1;
    @(posedge clk); #1; sb_empty = 1'b0;
    fork
      do_miss(32'h00A0_0010, 1'b1, 32'h00B0_0020, 128'hA5A5_0001_C3C3_0002_F0F0_0003_0F0F_0004);
      begin
        repeat (6) @(negedge clk);
        chk(!bus_req, "R2 held while store buffer busy", 128'(bus_req), 128'h0);
        @(posedge clk); #1; sb_empty = 1'b1;
      end
    join
    wait_idle();

    // R10: second miss requested during write-back
    ack_mode = 2;
    do_miss(32'h0300_0000, 1'b1, 32'h0400_0008, 128'hCAFE_0000_BEEF_1111_F00D_2222_ABCD_3333);
    do_miss(32'h0500_0004, 1'b1, 32'h0600_000C, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10);
    wait_idle();
    do_miss(32'h0700_0000, 1'b0, 32'h0, 128'h0);
    wait_idle();
    chk(busy_in_push_bad == 0, "R10 busy during write-back", 128'(busy_in_push_bad), 128'h0);
    // R11 is covered by the per-cycle direction compare across all bursts
    chk(write_beats % 4 == 0, "R11 whole write bursts", 128'(write_beats % 4), 128'h0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule